// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Condition Flags

This block is the combinational data path of a small 8-bit microcontroller core. From an operation code, two 8-bit operands and the present carry, half-carry, zero and overflow flags, it produces an 8-bit result and the next value of each flag. Each flag also has a write-enable output. The enable tells the surrounding status logic whether the operation defines that flag. When an enable is low, the matching flag output repeats the flag input, so the status register can load all four outputs every cycle.

The unit covers binary addition and subtraction, with and without the incoming carry. It also covers decimal adjust after a packed-BCD addition, bitwise AND, OR, XOR and complement, rotates with and without the carry, and increment and decrement. After a subtraction the carry flag means "no borrow". The half-carry flag follows the boundary between the two nibbles in both directions. Overflow is the carry into the top bit XOR the carry out of it. The block holds no state, so it has no clock and no reset; a result follows its inputs within the same cycle.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+c_in. The result is the low 8 bits and c_out is the carry out of bit 7.
- R2: Code 2 (subtract) gives A+~B+1 and code 3 (subtract with borrow) gives A+~B+c_in. c_out is the carry out of bit 7, so 1 means no borrow.
- R3: For codes 0 to 3, ac_out is the carry out of bit 3 of the same sum.
- R4: When z_wr is 1, z_out is 1 exactly when the result is zero. z_wr is 1 for codes 0, 1, 2, 3, 5, 6, 7, 8, 13 and 14.
- R5: For codes 0 to 3, ov_out is the carry into bit 7 XOR the carry out of bit 7.
- R6: Code 5 gives A AND B, 6 gives A OR B, 7 gives A XOR B and 8 gives NOT A. These four codes write Z only.
- R7: Code 13 gives A+1 and code 14 gives A-1, both modulo 256. These two codes write Z only.
- R8: Code 9 rotates A left (bit 7 to bit 0) and code 10 rotates A right (bit 0 to bit 7). Neither code writes any flag.
- R9: Code 11 rotates A left through the carry: c_in enters bit 0 and bit 7 goes to c_out. Code 12 rotates A right through the carry: c_in enters bit 7 and bit 0 goes to c_out. Both codes write C only.
- R10: Code 4 (decimal adjust) takes A and first adds 06h if A[3:0]>9 or ac_in=1. It then adds 60h if the upper nibble of that sum is above 9, if c_in=1, or if the first addition carried out. c_out is c_in OR any carry out of bit 7, so this code never clears C. Code 4 writes C only.
- R11: Each flag whose write-enable is 0 is output unchanged from its input. c_wr, ac_wr, z_wr and ov_wr match the write sets given in R1 to R10 and R12.
- R12: Code 15 passes A through unchanged and writes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (A) |
| opb | input | 8 | Second operand (B) |
| c_in | input | 1 | Present carry flag |
| ac_in | input | 1 | Present half-carry flag |
| z_in | input | 1 | Present zero flag |
| ov_in | input | 1 | Present overflow flag |
| result | output | 8 | Operation result |
| c_out | output | 1 | Next carry flag |
| ac_out | output | 1 | Next half-carry flag |
| z_out | output | 1 | Next zero flag |
| ov_out | output | 1 | Next overflow flag |
| c_wr | output | 1 | Operation defines carry |
| ac_wr | output | 1 | Operation defines half-carry |
| z_wr | output | 1 | Operation defines zero |
| ov_wr | output | 1 | Operation defines overflow |

## Verification
There is no stored state, so any fault shows at the outputs in the same cycle that the faulty opcode is applied. It stays there as long as that input pattern is held. A wrong operand selection or carry-in for the shared adder corrupts result, C, AC and OV together for the affected code. A wrong write-enable leaves a flag output equal to its input, or replaces it, and only input patterns whose old and new flag values differ can show this. For that reason the random flag inputs are varied independently of the operands. Decimal-adjust faults show only near the 9/10 nibble boundaries, so those values are applied directly.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_DAA  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_RL   = 4'd9,
        OP_RR   = 4'd10,
        OP_RLC  = 4'd11,
        OP_RRC  = 4'd12,
        OP_INC  = 4'd13,
        OP_DEC  = 4'd14,
        OP_PASS = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic ac;
        logic z;
        logic ov;
    } flag_s;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8,
    localparam int NW = DW / 2
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          c_half,
    output logic          c_into_msb
);
    logic [DW:0]   full;
    logic [NW:0]   low;
    logic [DW-1:0] upto_msb;

    always_comb begin
        full       = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        low        = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        upto_msb   = {1'b0, a[DW-2:0]} + {1'b0, b[DW-2:0]} + {{(DW-1){1'b0}}, cin};
        sum        = full[DW-1:0];
        cout       = full[DW];
        c_half     = low[NW];
        c_into_msb = upto_msb[DW-1];
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
    parameter int DW = 8,
    localparam int NW = DW / 2
) (
    input  logic [DW-1:0] a,
    input  logic          c_in,
    input  logic          ac_in,
    output logic [DW-1:0] res,
    output logic          cout
);
    localparam logic [DW:0] LO_FIX = (DW+1)'(6);
    localparam logic [DW:0] HI_FIX = (DW+1)'(6) << NW;
    localparam logic [NW-1:0] DIGIT_MAX = NW'(9);

    logic          lo_adj;
    logic          hi_adj;
    logic [DW:0]   step1;
    logic [DW:0]   step2;

    always_comb begin
        lo_adj = ac_in || (a[NW-1:0] > DIGIT_MAX);
        step1  = {1'b0, a} + (lo_adj ? LO_FIX : '0);
        hi_adj = c_in || step1[DW] || (step1[DW-1:NW] > DIGIT_MAX);
        step2  = {1'b0, step1[DW-1:0]} + (hi_adj ? HI_FIX : '0);
        res    = step2[DW-1:0];
        cout   = c_in | step1[DW] | step2[DW];
    end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic          go_right,
    input  logic          thru_c,
    output logic [DW-1:0] res,
    output logic          cout
);
    logic fill;

    always_comb begin
        if (go_right) begin
            fill = thru_c ? cin : a[0];
            res  = {fill, a[DW-1:1]};
            cout = a[0];
        end else begin
            fill = thru_c ? cin : a[DW-1];
            res  = {a[DW-2:0], fill};
            cout = a[DW-1];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          c_in,
    input  logic          ac_in,
    input  logic          z_in,
    input  logic          ov_in,
    output logic [DW-1:0] result,
    output logic          c_out,
    output logic          ac_out,
    output logic          z_out,
    output logic          ov_out,
    output logic          c_wr,
    output logic          ac_wr,
    output logic          z_wr,
    output logic          ov_wr
);
    alu_op_e       op_e;
    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [DW-1:0] add_sum;
    logic          add_cout;
    logic          add_chalf;
    logic          add_c7;
    logic [DW-1:0] daa_res;
    logic          daa_cout;
    logic          rot_right;
    logic          rot_thru;
    logic [DW-1:0] rot_res;
    logic          rot_cout;
    flag_s         fnew;
    flag_s         fwr;

    assign op_e = alu_op_e'(op);

    // operand steering for the shared adder
    always_comb begin
        add_b   = opb;
        add_cin = 1'b0;
        unique case (op_e)
            OP_ADC:  add_cin = c_in;
            OP_SUB:  begin add_b = ~opb; add_cin = 1'b1; end
            OP_SBC:  begin add_b = ~opb; add_cin = c_in; end
            OP_INC:  begin add_b = '0;   add_cin = 1'b1; end
            OP_DEC:  add_b = '1;
            default: ;
        endcase
    end

    assign rot_right = (op_e == OP_RR) || (op_e == OP_RRC);
    assign rot_thru  = (op_e == OP_RLC) || (op_e == OP_RRC);

    alu8_addsub #(.DW(DW)) u_addsub (
        .a(opa), .b(add_b), .cin(add_cin),
        .sum(add_sum), .cout(add_cout),
        .c_half(add_chalf), .c_into_msb(add_c7)
    );

    alu8_decadj #(.DW(DW)) u_decadj (
        .a(opa), .c_in(c_in), .ac_in(ac_in),
        .res(daa_res), .cout(daa_cout)
    );

    alu8_rotate #(.DW(DW)) u_rotate (
        .a(opa), .cin(c_in), .go_right(rot_right), .thru_c(rot_thru),
        .res(rot_res), .cout(rot_cout)
    );

    // result selection and flag write sets
    always_comb begin
        result = opa;
        fwr    = '0;
        fnew   = '{c: c_in, ac: ac_in, z: 1'b0, ov: ov_in};
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result = add_sum;
                fwr    = '{c: 1'b1, ac: 1'b1, z: 1'b1, ov: 1'b1};
                fnew.c  = add_cout;
                fnew.ac = add_chalf;
                fnew.ov = add_c7 ^ add_cout;
            end
            OP_DAA: begin
                result = daa_res;
                fwr.c  = 1'b1;
                fnew.c = daa_cout;
            end
            OP_AND:  begin result = opa & opb; fwr.z = 1'b1; end
            OP_OR:   begin result = opa | opb; fwr.z = 1'b1; end
            OP_XOR:  begin result = opa ^ opb; fwr.z = 1'b1; end
            OP_CPL:  begin result = ~opa;      fwr.z = 1'b1; end
            OP_RL, OP_RR: result = rot_res;
            OP_RLC, OP_RRC: begin
                result = rot_res;
                fwr.c  = 1'b1;
                fnew.c = rot_cout;
            end
            OP_INC, OP_DEC: begin result = add_sum; fwr.z = 1'b1; end
            OP_PASS: result = opa;
        endcase
        fnew.z = (result == '0);
    end

    assign c_wr   = fwr.c;
    assign ac_wr  = fwr.ac;
    assign z_wr   = fwr.z;
    assign ov_wr  = fwr.ov;
    assign c_out  = fwr.c  ? fnew.c  : c_in;
    assign ac_out = fwr.ac ? fnew.ac : ac_in;
    assign z_out  = fwr.z  ? fnew.z  : z_in;
    assign ov_out = fwr.ov ? fnew.ov : ov_in;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic [3:0] op,
    input logic [7:0] opa,
    input logic [7:0] opb,
    input logic       c_in,
    input logic       ac_in,
    input logic       z_in,
    input logic       ov_in,
    input logic [7:0] result,
    input logic       c_out,
    input logic       ac_out,
    input logic       z_out,
    input logic       ov_out,
    input logic       c_wr,
    input logic       ac_wr,
    input logic       z_wr,
    input logic       ov_wr
);
    logic known;
    assign known = !$isunknown({op, opa, opb, c_in, ac_in, z_in, ov_in});

    always_comb begin
        if (known) begin
            // R4
            zero_flag_chk: assert (!z_wr || (z_out == (result == 8'h00)));
            // R11
            carry_hold_chk: assert (c_wr || (c_out == c_in));
            // R11
            flags_hold_chk: assert ((ac_wr || ac_out == ac_in) && (ov_wr || ov_out == ov_in));
            // R1
            add_sum_chk: assert (op != 4'd0 || ({c_out, result} == {1'b0, opa} + {1'b0, opb}));
            // R5
            add_ovf_chk: assert (op != 4'd0 || (ov_out == ((opa[7] == opb[7]) && (result[7] != opa[7]))));
            // R8
            plain_rot_chk: assert (!(op == 4'd9 || op == 4'd10) || !(c_wr || ac_wr || z_wr || ov_wr));
            // R10
            dec_adj_carry_chk: assert (op != 4'd4 || !c_in || c_out);
            // R12
            pass_thru_chk: assert (op != 4'd15 || (result == opa && $countones({c_wr, ac_wr, z_wr, ov_wr}) == 0));
        end
    end
endmodule

bind alu8_core alu8_core_chk u_chk (
    .op(op), .opa(opa), .opb(opb),
    .c_in(c_in), .ac_in(ac_in), .z_in(z_in), .ov_in(ov_in),
    .result(result), .c_out(c_out), .ac_out(ac_out), .z_out(z_out), .ov_out(ov_out),
    .c_wr(c_wr), .ac_wr(ac_wr), .z_wr(z_wr), .ov_wr(ov_wr)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op = '0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic       c_in = 1'b0, ac_in = 1'b0, z_in = 1'b0, ov_in = 1'b0;
    logic [7:0] result;
    logic       c_out, ac_out, z_out, ov_out;
    logic       c_wr, ac_wr, z_wr, ov_wr;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    alu8_core uut (
        .op(op), .opa(opa), .opb(opb),
        .c_in(c_in), .ac_in(ac_in), .z_in(z_in), .ov_in(ov_in),
        .result(result), .c_out(c_out), .ac_out(ac_out), .z_out(z_out), .ov_out(ov_out),
        .c_wr(c_wr), .ac_wr(ac_wr), .z_wr(z_wr), .ov_wr(ov_wr)
    );

    // packed expectation: {result, c, ac, z, ov, wc, wac, wz, wov}
    function automatic logic [15:0] model(input int o, input int a, input int b,
                                          input int c, input int ac, input int z, input int ov);
        int r, nc, nac, nz, nov, wc, wac, wz, wov, bb, ci, s, c7, t1, hi;
        r = a; nc = c; nac = ac; nz = z; nov = ov;
        wc = 0; wac = 0; wz = 0; wov = 0;
        bb = b; ci = 0;
        case (o)
            0, 1, 2, 3: begin
                if (o >= 2) bb = 255 - b;
                ci = (o == 0) ? 0 : (o == 2) ? 1 : c;
                s   = a + bb + ci;
                r   = s % 256;
                nc  = s / 256;
                nac = ((a % 16) + (bb % 16) + ci) / 16;
                c7  = ((a % 128) + (bb % 128) + ci) / 128;
                nov = c7 ^ nc;
                wc = 1; wac = 1; wz = 1; wov = 1;
            end
            4: begin
                t1 = a + ((ac == 1 || (a % 16) > 9) ? 6 : 0);
                hi = (t1 % 256) / 16;
                s  = (t1 % 256) + ((c == 1 || t1 > 255 || hi > 9) ? 96 : 0);
                r  = s % 256;
                nc = (c == 1 || t1 > 255 || s > 255) ? 1 : 0;
                wc = 1;
            end
            5:  begin r = a & b;   wz = 1; end
            6:  begin r = a | b;   wz = 1; end
            7:  begin r = a ^ b;   wz = 1; end
            8:  begin r = 255 - a; wz = 1; end
            9:  r = ((a * 2) % 256) + a / 128;
            10: r = a / 2 + (a % 2) * 128;
            11: begin r = ((a * 2) % 256) + c;  nc = a / 128; wc = 1; end
            12: begin r = a / 2 + c * 128;     nc = a % 2;   wc = 1; end
            13: begin r = (a + 1) % 256;   wz = 1; end
            14: begin r = (a + 255) % 256; wz = 1; end
            default: r = a;
        endcase
        if (wz == 1) nz = (r == 0) ? 1 : 0;
        model = {r[7:0], nc[0], nac[0], nz[0], nov[0], wc[0], wac[0], wz[0], wov[0]};
    endfunction

    function automatic string tag_of(input int o);
        case (o)
            0, 1:         tag_of = "R1 R3 R4 R5 R11";
            2, 3:         tag_of = "R2 R3 R4 R5 R11";
            4:            tag_of = "R10 R11";
            5, 6, 7, 8:   tag_of = "R6 R4 R11";
            9, 10:        tag_of = "R8 R11";
            11, 12:       tag_of = "R9 R11";
            13, 14:       tag_of = "R7 R4 R11";
            default:      tag_of = "R12 R11";
        endcase
    endfunction

    task automatic apply(input int o, input int a, input int b,
                         input int c, input int ac, input int z, input int ov, input string why);
        logic [15:0] exp_v, act_v;
        @(negedge clk);
        op = o[3:0]; opa = a[7:0]; opb = b[7:0];
        c_in = c[0]; ac_in = ac[0]; z_in = z[0]; ov_in = ov[0];
        #2;
        exp_v = model(o, a, b, c, ac, z, ov);
        act_v = {result, c_out, ac_out, z_out, ov_out, c_wr, ac_wr, z_wr, ov_wr};
        n_vec++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s [%s] op=%0d a=%h b=%h c=%0d ac=%0d: actual=%h expected=%h",
                     why, tag_of(o), o, a, b, c, ac, act_v, exp_v);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_0a1b;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs select add of zeros
        apply(0, 0, 0, 0, 0, 0, 0, "reset R1 R4");
        // R1 directed carry and overflow
        apply(0, 8'hFF, 8'h01, 0, 0, 0, 0, "R1 wrap zero");
        apply(0, 8'h7F, 8'h01, 0, 0, 0, 0, "R5 pos overflow");
        apply(1, 8'h0F, 8'h00, 1, 0, 0, 0, "R1 R3 half carry");
        // R2 no-borrow convention
        apply(2, 8'h05, 8'h05, 0, 0, 0, 0, "R2 equal");
        apply(2, 8'h03, 8'h05, 1, 1, 1, 1, "R2 borrow");
        apply(3, 8'h80, 8'h01, 0, 0, 0, 0, "R2 R5 sbc overflow");
        apply(2, 8'h10, 8'h01, 0, 1, 0, 0, "R3 nibble borrow");
        // R10 decimal adjust corners
        apply(4, 8'h9A, 0, 0, 0, 0, 0, "R10 both adjust");
        apply(4, 8'h09, 0, 0, 1, 0, 0, "R10 ac adjust");
        apply(4, 8'h99, 0, 0, 0, 0, 0, "R10 no adjust");
        apply(4, 8'h12, 0, 1, 0, 0, 0, "R10 carry kept");
        apply(4, 8'hFA, 0, 0, 0, 0, 0, "R10 low carry");
        // R6 R7 R8 R9 R12 directed
        apply(5, 8'hF0, 8'h0F, 1, 1, 0, 1, "R6 and zero");
        apply(8, 8'hFF, 0, 0, 0, 0, 0, "R6 cpl zero");
        apply(13, 8'hFF, 0, 1, 1, 0, 1, "R7 inc wrap");
        apply(14, 8'h00, 0, 0, 0, 1, 0, "R7 dec wrap");
        apply(9, 8'h81, 0, 1, 1, 1, 1, "R8 rl flags held");
        apply(10, 8'h01, 0, 0, 0, 0, 0, "R8 rr flags held");
        apply(11, 8'h80, 0, 0, 1, 1, 1, "R9 rlc");
        apply(12, 8'h01, 0, 1, 0, 0, 0, "R9 rrc");
        apply(15, 8'h00, 8'hFF, 1, 1, 0, 1, "R12 pass");
        // constrained random: every opcode, independent flags
        for (int i = 0; i < 3000; i++) begin
            int o, a, b;
            o = int'($urandom_range(0, 15));
            a = int'($urandom_range(0, 255));
            b = int'($urandom_range(0, 255));
            if ($urandom_range(0, 7) == 0) a = (a % 2 == 0) ? 0 : 255;
            apply(o, a, b, int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), "random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule